// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address by walking a three-level radix page table stored in memory. A request carries the virtual address, the hart's current privilege mode and the value of the address-translation control register. When translation is off, the block returns the virtual address unchanged and makes no memory access. When translation is on, it reads one 64-bit entry per level through a simple synchronous read port. It stops at the first entry that is a leaf, and it can stop at any of the three levels.

The result is either a one-cycle done pulse with a zero-extended 56-bit physical address or a one-cycle fault pulse. The physical address is built from the entry's physical page number and the low bits of the virtual address. Which bits come from where depends on whether the walk ended on a 1 GiB, 2 MiB or 4 KiB page. The block is meant to sit behind a translation cache or a debug path that needs an occasional walk. It accepts one request at a time and ignores requests while a walk is running.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into a 12-bit offset (bits 11:0) and three 9-bit page-number fields: bits 20:12 for level 0, bits 29:21 for level 1 and bits 38:30 for level 2. Each read address is the current table base plus that level's page-number field times 8, so every read address is 8-byte aligned. Bits 63:39 of the virtual address do not affect the walk.
- R2: Translation is active only when control bit 63 is 1 and the mode input is not machine mode (2'b11). Otherwise the block pulses `resp_done` one cycle after it accepts the request, with `resp_paddr` equal to the full 64-bit `req_vaddr`, and it makes no memory read.
- R3: The first read uses the root table base, which is control bits 43:0 shifted left by 12.
- R4: An entry is a leaf when bit 1 (read) or bit 3 (execute) is 1; an entry with only bit 3 set is also a leaf. A valid non-leaf entry makes the walk go down one level, using entry bits 53:10 shifted left by 12 as the next table base.
- R5: A leaf at level 2 gives a 1 GiB page. The address is entry bits 53:28 above virtual bits 29:0.
- R6: A leaf at level 1 gives a 2 MiB page. The address is entry bits 53:19 above virtual bits 20:0.
- R7: A leaf at level 0 gives a 4 KiB page. The address is entry bits 53:10 above virtual bits 11:0, and bits 63:56 of the result are zero.
- R8: If a fetched entry has its valid bit (bit 0) clear, or an entry at level 0 is not a leaf, the block pulses `resp_fault` and drives `resp_paddr` to zero.
- R9: A 1 GiB leaf with any of entry bits 27:10 set faults. A 2 MiB leaf with any of entry bits 18:10 set faults.
- R10: Only one read is outstanding at a time, and read data is taken the cycle after `mem_rd_en`. `busy` is high from acceptance until completion. Requests made while `busy` is high are ignored. `resp_done` and `resp_fault` are single-cycle pulses and never high together.
- R11: Counted from the clock edge that accepts the request, a walk completes in 2·k+1 cycles, where k is the number of entries read: 3 cycles for one entry, 5 for two, 7 for three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_vaddr | input | 64 | Virtual address to translate |
| req_mode | input | 2 | Current privilege mode (2'b11 = machine) |
| req_ctrl | input | 64 | Translation control register value |
| busy | output | 1 | A walk is in progress |
| mem_rd_en | output | 1 | Read strobe to table memory |
| mem_rd_addr | output | 56 | Byte address of the entry to read |
| mem_rd_data | input | 64 | Entry data, valid the cycle after the strobe |
| resp_done | output | 1 | Translation complete pulse |
| resp_fault | output | 1 | Walk failed pulse |
| resp_paddr | output | 64 | Translated address, valid with `resp_done` |

## Verification
The bench builds the block with its default parameters: machine mode encoded as 2'b11 and the enable flag at control bit 63. With these values both bypass conditions can be reached, as can walks that stop at each of the three levels. The table lives in a small sparse memory model, so a leaf can sit at any level. Entries can be invalid, non-leaf at the bottom level, or superpages with stray low page-number bits, which covers every fault path and every address layout. Each walk's read addresses and latency are logged and compared with values derived from the field split.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter logic [1:0] MMODE  = 2'b11,
  parameter int         EN_BIT = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_mode,
  input  logic [63:0] req_ctrl,
  output logic        busy,
  output logic        mem_rd_en,
  output logic [55:0] mem_rd_addr,
  input  logic [63:0] mem_rd_data,
  output logic        resp_done,
  output logic        resp_fault,
  output logic [63:0] resp_paddr
);
  localparam int PA_W  = 56;
  localparam int OFF_W = 12;
  localparam int VPN_W = 9;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t             state;
  logic [1:0]      lvl;
  logic [PA_W-1:0] base;
  logic [38:0]     va_q;
  logic [VPN_W-1:0] vpn_sel;
  logic [PA_W-1:0] leaf_pa;
  logic            xlate_on, pte_v, pte_leaf, misal;

  assign xlate_on = req_ctrl[EN_BIT] && (req_mode != MMODE);
  assign busy     = (state != S_IDLE);

  always_comb begin
    case (lvl)
      2'd2:    vpn_sel = va_q[38:30];
      2'd1:    vpn_sel = va_q[29:21];
      default: vpn_sel = va_q[20:12];
    endcase
  end

  assign mem_rd_en   = (state == S_ISSUE);
  assign mem_rd_addr = base + {{(PA_W-VPN_W-3){1'b0}}, vpn_sel, 3'b000};

  assign pte_v    = mem_rd_data[0];
  assign pte_leaf = mem_rd_data[1] | mem_rd_data[3];
  assign misal    = ((lvl == 2'd2) && (mem_rd_data[27:10] != '0)) ||
                    ((lvl == 2'd1) && (mem_rd_data[18:10] != '0));

  always_comb begin
    case (lvl)
      2'd2:    leaf_pa = {mem_rd_data[53:28], va_q[29:0]};
      2'd1:    leaf_pa = {mem_rd_data[53:19], va_q[20:0]};
      default: leaf_pa = {mem_rd_data[53:10], va_q[OFF_W-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      lvl        <= 2'd2;
      base       <= '0;
      va_q       <= '0;
      resp_done  <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_done  <= 1'b0;
      resp_fault <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (!xlate_on) begin
              resp_done  <= 1'b1;
              resp_paddr <= req_vaddr;
            end else begin
              va_q       <= req_vaddr[38:0];
              base       <= {req_ctrl[43:0], {OFF_W{1'b0}}};
              lvl        <= 2'd2;
              resp_paddr <= '0;
              state      <= S_ISSUE;
            end
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (!pte_v) begin
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            state      <= S_IDLE;
          end else if (pte_leaf) begin
            if (misal) begin
              resp_fault <= 1'b1;
              resp_paddr <= '0;
            end else begin
              resp_done  <= 1'b1;
              resp_paddr <= {{(64-PA_W){1'b0}}, leaf_pa};
            end
            state <= S_IDLE;
          end else if (lvl == 2'd0) begin
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            state      <= S_IDLE;
          end else begin
            base  <= {mem_rd_data[53:10], {OFF_W{1'b0}}};
            lvl   <= lvl - 2'd1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk #(
  parameter logic [1:0] MMODE  = 2'b11,
  parameter int         EN_BIT = 63
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] req_vaddr,
  input logic [1:0]  req_mode,
  input logic [63:0] req_ctrl,
  input logic        busy,
  input logic        mem_rd_en,
  input logic [55:0] mem_rd_addr,
  input logic        resp_done,
  input logic        resp_fault,
  input logic [63:0] resp_paddr
);
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !(req_ctrl[EN_BIT] && req_mode != MMODE))
    |=> (resp_done && resp_paddr == $past(req_vaddr)));

  p_read_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[2:0] == 3'b000));

  p_fault_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (resp_paddr == 64'd0));

  p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_read_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  p_done_fault_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_fault));

  p_idle_on_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done || resp_fault) |-> !busy);
endmodule

bind pt_walker pt_walker_chk #(.MMODE(MMODE), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_mode(req_mode), .req_ctrl(req_ctrl), .busy(busy),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .resp_done(resp_done), .resp_fault(resp_fault), .resp_paddr(resp_paddr));

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_mode = 2'b00;
  logic [63:0] req_ctrl = '0;
  logic        busy, mem_rd_en, resp_done, resp_fault;
  logic [55:0] mem_rd_addr;
  logic [63:0] mem_rd_data = '0;
  logic [63:0] resp_paddr;

  int checks = 0;
  int errors = 0;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .req_ctrl(req_ctrl), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .resp_done(resp_done), .resp_fault(resp_fault), .resp_paddr(resp_paddr));

  always #2 clk = ~clk;

  logic [63:0] mem [0:4095];
  logic [55:0] rd_log [0:7];
  int rd_cnt = 0;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[{mem_rd_addr[14:12], mem_rd_addr[11:3]}];
      if (rd_cnt < 8) rd_log[rd_cnt] <= mem_rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  localparam logic [63:0] EN   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] CTRL = EN | 64'd1;

  function automatic logic [63:0] mkpte(input logic [43:0] ppn, input logic [3:0] fl);
    return {10'd0, ppn, 6'd0, fl};
  endfunction

  function automatic logic [63:0] mkva(input int v2, input int v1, input int v0, input int off);
    return (64'(v2) << 30) | (64'(v1) << 21) | (64'(v0) << 12) | 64'(off);
  endfunction

  task automatic put(input int page, input int idx, input logic [63:0] v);
    mem[page * 512 + idx] = v;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] md, input logic [63:0] ctl,
                     input bit inject, output logic [63:0] pa, output bit flt,
                     output int cyc, output int ndone);
    @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va; req_mode = md; req_ctrl = ctl; req_valid = 1'b1;
    cyc = 0; ndone = 0; pa = '0; flt = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc++;
      req_valid = (inject && cyc == 2);
      if (inject && cyc == 2) begin
        req_vaddr = 64'h1234; req_mode = 2'b00; req_ctrl = 64'd0;
      end
      if (resp_done || resp_fault) begin
        ndone++;
        pa = resp_paddr;
        flt = resp_fault;
        break;
      end
    end
    req_valid = 1'b0;
  endtask

  logic [63:0] pa;
  bit flt;
  int cyc, nd;

  task automatic t_reset();
    chk(!busy && !mem_rd_en && !resp_done && !resp_fault && resp_paddr == 0,
        "R10 reset state idle", {busy, mem_rd_en, resp_done, resp_fault}, 64'd0);
  endtask

  task automatic t_bypass();
    logic [63:0] va = 64'hFFFF_0000_1234_5678;
    run(va, 2'b00, 64'd1, 1'b0, pa, flt, cyc, nd);
    chk(!flt && pa == va, "R2 disabled passthrough addr", pa, va);
    chk(cyc == 1 && rd_cnt == 0, "R2 disabled no read one cycle", 64'(cyc*16 + rd_cnt), 64'd16);
    run(va, 2'b11, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(!flt && pa == va && rd_cnt == 0, "R2 machine mode passthrough", pa, va);
  endtask

  task automatic t_small_page();
    logic [63:0] va = mkva(5, 7, 9, 'h123) | 64'h0004_0000_0000_0000;
    logic [63:0] ex = (64'h0ABCDE << 12) | 64'h123;
    run(va, 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(!flt && pa == ex, "R7 4KiB address", pa, ex);
    chk(cyc == 7, "R11 three-level latency", 64'(cyc), 64'd7);
    chk(rd_cnt == 3, "R10 three reads", 64'(rd_cnt), 64'd3);
    chk(rd_log[0] == 56'h1000 + 5*8, "R3 root read address", 64'(rd_log[0]), 64'h1028);
    chk(rd_log[1] == 56'h2000 + 7*8, "R4 level1 base from entry", 64'(rd_log[1]), 64'h2038);
    chk(rd_log[2] == 56'h3000 + 9*8, "R1 level0 read address", 64'(rd_log[2]), 64'h3048);
    run(mkva(5, 7, 13, 'hFFF), 2'b01, CTRL, 1'b0, pa, flt, cyc, nd);
    ex = (64'h00777 << 12) | 64'hFFF;
    chk(!flt && pa == ex, "R4 execute-only leaf", pa, ex);
  endtask

  task automatic t_mega();
    logic [63:0] va = mkva(5, 8, 300, 'h456);
    logic [63:0] ex = (64'h54000 << 12) | (va & 64'h1F_FFFF);
    run(va, 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(!flt && pa == ex, "R6 2MiB address", pa, ex);
    chk(cyc == 5 && rd_cnt == 2, "R11 two-level latency", 64'(cyc), 64'd5);
  endtask

  task automatic t_giga();
    logic [63:0] va = mkva(6, 411, 77, 'hABC);
    logic [63:0] ex = (64'h40000 << 12) | (va & 64'h3FFF_FFFF);
    run(va, 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(!flt && pa == ex, "R5 1GiB address", pa, ex);
    chk(cyc == 3 && rd_cnt == 1, "R11 one-level latency", 64'(cyc), 64'd3);
  endtask

  task automatic t_faults();
    run(mkva(7, 0, 0, 0), 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(flt && pa == 0, "R8 invalid root entry faults", {63'd0, flt}, 64'd1);
    run(mkva(5, 10, 0, 0), 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(flt && pa == 0 && rd_cnt == 2, "R8 invalid level1 entry faults", 64'(rd_cnt), 64'd2);
    run(mkva(5, 7, 11, 0), 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(flt && pa == 0 && rd_cnt == 3, "R8 non-leaf at level0 faults", {63'd0, flt}, 64'd1);
    run(mkva(8, 0, 0, 0), 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(flt && pa == 0, "R9 misaligned 1GiB faults", pa, 64'd0);
    run(mkva(5, 12, 0, 0), 2'b00, CTRL, 1'b0, pa, flt, cyc, nd);
    chk(flt && pa == 0, "R9 misaligned 2MiB faults", pa, 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] ex = (64'h0ABCDE << 12) | 64'h123;
    run(mkva(5, 7, 9, 'h123), 2'b00, CTRL, 1'b1, pa, flt, cyc, nd);
    chk(!flt && pa == ex && cyc == 7, "R10 request while busy ignored", pa, ex);
    chk(rd_cnt == 3, "R10 no extra reads from ignored request", 64'(rd_cnt), 64'd3);
    @(negedge clk);
    chk(!resp_done && !resp_fault && !busy, "R10 single pulse then idle",
        {62'd0, resp_done, resp_fault}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    put(1, 5, mkpte(44'd2, 4'b0001));
    put(2, 7, mkpte(44'd3, 4'b0001));
    put(3, 9, mkpte(44'h0ABCDE, 4'b0011));
    put(3, 13, mkpte(44'h00777, 4'b1001));
    put(3, 11, mkpte(44'h00077, 4'b0001));
    put(2, 8, mkpte(44'h54000, 4'b1011));
    put(2, 12, mkpte(44'h54001, 4'b0011));
    put(1, 6, mkpte(44'h40000, 4'b1001));
    put(1, 7, mkpte(44'd2, 4'b0010));
    put(1, 8, mkpte(44'h40001, 4'b0011));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bypass();
    t_small_page();
    t_mega();
    t_giga();
    t_faults();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule